// File: doc/BRIEF.md
# Linear CCD Readout Timing Sequencer

This block drives a 2048-pixel linear CCD image sensor from a fast system clock. It makes the sensor's pixel shift clock and its readout-gate pulse. It counts the pixel periods of every line and labels each period by class: dummy, optical black, effective or idle. For effective pixels it also gives a pixel index. An ADC sample strobe fires at a chosen point inside every pixel period of the line. A host starts lines with a one-cycle start pulse. It sees a busy level and a one-cycle line-done pulse.

After reset the sequencer clocks the sensor for a long warm-up run. No line is produced during this run. After that, each line goes through the same steps. The shift clock is parked high for a guard time. The readout gate is raised for a fixed width. The clock is parked for the guard time again. Then a fixed number of shift periods is clocked out. This number is larger than the longest line, so the sensor always receives enough pulses between gate pulses. The sample-and-hold option adds one leading dummy period to the line. The option is latched at the start of each line. All timing lengths are parameters counted in system-clock cycles. Values that break the sensor's minimum timings are rejected at elaboration.

Top module: `ccd_readout_seq`

## Requirements
- R1: After reset the block issues WARM_PULSES shift periods without a readout gate. During this time `warm_o` and `busy_o` are high and the class is idle (3). It then goes idle with `sclk_o` high and `busy_o` low. The first cycle after reset has `sclk_o` low.
- R2: A start seen at a clock edge while idle begins a line in the next cycle. `busy_o` stays high through the whole line and drops in the cycle after its last shift period.
- R3: `sclk_o` is held high for GUARD_CYC cycles before the readout gate rises, and for GUARD_CYC cycles after it falls, before the first shift period.
- R4: `rog_o` is high for exactly ROG_CYC cycles per line, and `sclk_o` stays high while it is high.
- R5: Each shift period is HALF_CYC cycles low followed by HALF_CYC cycles high. A line always has LEAD_PIX+1+EFF_PIX+TRAIL_PIX+EXTRA_PULSES periods, whatever the mode.
- R6: Without hold mode, `pix_class_o` numbers the line's periods from 0. Periods below LEAD_PIX-OB_PIX are dummy (code 0). The next OB_PIX periods are optical black (code 1). The next EFF_PIX periods are effective (code 2), with `pix_idx_o` counting from 0. The next TRAIL_PIX periods are dummy. The remaining periods, and all time outside shifting, are idle (code 3). `pix_idx_o` is 0 whenever the class is not effective.
- R7: With `hold_mode_i` high when a line starts, every region after the first one is shifted one period later, because the line gains one extra leading dummy period. `mode_o` shows the latched mode. A change of `hold_mode_i` during a line has no effect on that line.
- R8: `smp_stb_o` is a one-cycle pulse. It fires `smp_dly_i` cycles after the start of each pixel period of the line (0 means the first cycle of the period). It never fires in the extra periods or outside shifting. With a delay of 2*HALF_CYC or more it never fires.
- R9: `line_done_o` pulses for one cycle, in the last cycle of the last trailing dummy period.
- R10: A start that arrives during warm-up or during a line is held, and begins the next line after one idle cycle. Several such starts merge into a single pending line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Line request pulse |
| hold_mode_i | input | 1 | Sample-and-hold mode request, latched at line start |
| smp_dly_i | input | DLY_W | Strobe delay from pixel-period start, in system cycles |
| sclk_o | output | 1 | Sensor shift clock |
| rog_o | output | 1 | Sensor readout-gate pulse |
| mode_o | output | 1 | Latched mode, drives the sensor mode pin |
| pix_class_o | output | 2 | Period class: 0 dummy, 1 black, 2 effective, 3 idle |
| pix_idx_o | output | IDX_W | Effective pixel index |
| smp_stb_o | output | 1 | ADC sample strobe |
| line_done_o | output | 1 | End-of-line pulse |
| busy_o | output | 1 | Warm-up or line in progress |
| warm_o | output | 1 | Warm-up in progress |

## Verification
The hardest case to reach from the ports is a line request that lands while the block cannot accept it: during warm-up, or while a line is being shifted. The bench handles this by pulsing start twice during warm-up and once again in the middle of the first line, and by changing the hold request at that same point. It then checks that exactly two back-to-back lines follow and that each has its own latched framing. The strobe delay is set to zero, to the last cycle of the period and to one full period. This covers the edges of a period and the case where the strobe is suppressed.

// File: rtl/ccd_seq_pkg.sv
package ccd_seq_pkg;

   typedef enum logic [1:0] {
      PX_DUMMY = 2'd0,
      PX_BLACK = 2'd1,
      PX_EFF   = 2'd2,
      PX_IDLE  = 2'd3
   } px_class_e;

   typedef enum logic [2:0] {
      ST_WARM,
      ST_IDLE,
      ST_PRE,
      ST_GATE,
      ST_POST,
      ST_SHIFT
   } seq_st_e;

endpackage

// File: rtl/ccd_sclk_gen.sv
module ccd_sclk_gen #(
   parameter int HALF_CYC = 63,
   parameter int PCNT_W   = 15
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              run_i,
   output logic              sclk_o,
   output logic              per_start_o,
   output logic              per_last_o,
   output logic [PCNT_W-1:0] pcnt_o
);
   localparam int HC_W = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;
   localparam logic [HC_W-1:0] HC_LAST = HC_W'(HALF_CYC - 1);

   logic [HC_W-1:0]   hcnt_q;
   logic              low_q;
   logic [PCNT_W-1:0] pcnt_q;
   logic              half_end;

   assign half_end = (hcnt_q == HC_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         hcnt_q <= '0;
         low_q  <= 1'b1;
         pcnt_q <= '0;
      end else if (!run_i) begin
         hcnt_q <= '0;
         low_q  <= 1'b1;
         pcnt_q <= '0;
      end else if (half_end) begin
         hcnt_q <= '0;
         low_q  <= ~low_q;
         if (!low_q) pcnt_q <= pcnt_q + 1'b1;
      end else begin
         hcnt_q <= hcnt_q + 1'b1;
      end
   end

   assign sclk_o      = ~(run_i & low_q);
   assign per_start_o = run_i & low_q & (hcnt_q == '0);
   assign per_last_o  = run_i & ~low_q & half_end;
   assign pcnt_o      = pcnt_q;

   // R5
   period_chain_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_last_o && run_i) |=> (!run_i || per_start_o));

endmodule

// File: rtl/ccd_strobe_gen.sv
module ccd_strobe_gen #(
   parameter int DLY_W = 8
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             act_i,
   input  logic             per_start_i,
   input  logic [DLY_W-1:0] dly_i,
   output logic             stb_o
);
   logic [DLY_W-1:0] cnt_q;
   logic             armed_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         armed_q <= 1'b0;
      end else if (!act_i) begin
         armed_q <= 1'b0;
      end else if (per_start_i) begin
         cnt_q   <= dly_i;
         armed_q <= (dly_i != '0);
      end else if (armed_q) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == DLY_W'(1)) armed_q <= 1'b0;
      end
   end

   assign stb_o = act_i & ((per_start_i & (dly_i == '0)) |
                           (armed_q & ~per_start_i & (cnt_q == DLY_W'(1))));

   // R8
   stb_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      stb_o |=> !stb_o);

endmodule

// File: rtl/ccd_pix_class.sv
module ccd_pix_class
   import ccd_seq_pkg::*;
#(
   parameter int EFF_PIX   = 2048,
   parameter int OB_PIX    = 18,
   parameter int LEAD_PIX  = 32,
   parameter int TRAIL_PIX = 8,
   parameter int PCNT_W    = 15,
   parameter int IDX_W     = 12
) (
   input  logic              act_i,
   input  logic              mode_i,
   input  logic [PCNT_W-1:0] pcnt_i,
   output logic [1:0]        class_o,
   output logic [IDX_W-1:0]  idx_o,
   output logic              in_line_o,
   output logic              last_o
);
   always_comb begin
      int p;
      int lead;
      int len;
      p    = int'(pcnt_i);
      lead = LEAD_PIX + int'(mode_i);
      len  = lead + EFF_PIX + TRAIL_PIX;
      class_o   = PX_IDLE;
      idx_o     = '0;
      in_line_o = act_i && (p < len);
      last_o    = act_i && (p == len - 1);
      if (in_line_o) begin
         if (p < lead - OB_PIX)          class_o = PX_DUMMY;
         else if (p < lead)              class_o = PX_BLACK;
         else if (p < lead + EFF_PIX) begin
            class_o = PX_EFF;
            idx_o   = IDX_W'(p - lead);
         end else                        class_o = PX_DUMMY;
      end
   end

endmodule

// File: rtl/ccd_readout_seq.sv
module ccd_readout_seq
   import ccd_seq_pkg::*;
#(
   parameter int SYS_PS       = 4000,
   parameter int HALF_CYC     = 63,
   parameter int ROG_CYC      = 1250,
   parameter int GUARD_CYC    = 750,
   parameter int WARM_PULSES  = 22500,
   parameter int EFF_PIX      = 2048,
   parameter int OB_PIX       = 18,
   parameter int LEAD_PIX     = 32,
   parameter int TRAIL_PIX    = 8,
   parameter int EXTRA_PULSES = 1,
   parameter bit HOLD_SUPPORT = 1'b1,
   parameter int IDX_W        = 12,
   parameter int DLY_W        = $clog2(2 * HALF_CYC) + 1
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             start_i,
   input  logic             hold_mode_i,
   input  logic [DLY_W-1:0] smp_dly_i,
   output logic             sclk_o,
   output logic             rog_o,
   output logic             mode_o,
   output logic [1:0]       pix_class_o,
   output logic [IDX_W-1:0] pix_idx_o,
   output logic             smp_stb_o,
   output logic             line_done_o,
   output logic             busy_o,
   output logic             warm_o
);
   localparam int SHOTS   = LEAD_PIX + 1 + EFF_PIX + TRAIL_PIX + EXTRA_PULSES;
   localparam int PMAX    = (WARM_PULSES > SHOTS) ? WARM_PULSES : SHOTS;
   localparam int PCNT_W  = $clog2(PMAX + 1);
   localparam int TMAX    = (ROG_CYC > GUARD_CYC) ? ROG_CYC : GUARD_CYC;
   localparam int TM_W    = $clog2(TMAX + 1);

   if (longint'(HALF_CYC) * SYS_PS < 250000)
      $error("shift clock faster than 2 MHz");
   if (longint'(ROG_CYC) * SYS_PS < 1000000)
      $error("readout gate shorter than 1 us");
   if (longint'(GUARD_CYC) * SYS_PS < 1000000)
      $error("gate guard shorter than 1 us");
   if (OB_PIX >= LEAD_PIX)
      $error("black region must leave a leading dummy");
   if (EFF_PIX > (1 << IDX_W))
      $error("pixel index too narrow");
   if (EXTRA_PULSES < 1)
      $error("need at least one shift pulse beyond the line");
   if ((1 << DLY_W) < 2 * HALF_CYC)
      $error("strobe delay cannot span a pixel period");

   seq_st_e           st_q, st_d;
   logic [TM_W-1:0]   tcnt_q;
   logic              pend_q, mode_q, take, tmr_last;
   logic              hold_req;
   logic              per_start, per_last, run, in_line, last_pix;
   logic [PCNT_W-1:0] pcnt;

   if (HOLD_SUPPORT) begin : g_hold
      assign hold_req = hold_mode_i;
   end else begin : g_nohold
      assign hold_req = 1'b0;
   end

   assign run      = (st_q == ST_WARM) || (st_q == ST_SHIFT);
   assign take     = (st_q == ST_IDLE) && (pend_q || start_i);
   assign tmr_last = (tcnt_q == ((st_q == ST_GATE) ? TM_W'(ROG_CYC - 1)
                                                   : TM_W'(GUARD_CYC - 1)));

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_WARM:  if (per_last && pcnt == PCNT_W'(WARM_PULSES - 1)) st_d = ST_IDLE;
         ST_IDLE:  if (take)     st_d = ST_PRE;
         ST_PRE:   if (tmr_last) st_d = ST_GATE;
         ST_GATE:  if (tmr_last) st_d = ST_POST;
         ST_POST:  if (tmr_last) st_d = ST_SHIFT;
         ST_SHIFT: if (per_last && pcnt == PCNT_W'(SHOTS - 1)) st_d = ST_IDLE;
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_WARM;
         tcnt_q <= '0;
         pend_q <= 1'b0;
         mode_q <= 1'b0;
      end else begin
         st_q   <= st_d;
         tcnt_q <= (st_d != st_q) ? '0 : tcnt_q + 1'b1;
         pend_q <= (pend_q | start_i) & ~take;
         if (take) mode_q <= hold_req;
      end
   end

   ccd_sclk_gen #(.HALF_CYC(HALF_CYC), .PCNT_W(PCNT_W)) u_sclk (
      .clk_i, .rst_ni, .run_i(run), .sclk_o,
      .per_start_o(per_start), .per_last_o(per_last), .pcnt_o(pcnt));

   ccd_pix_class #(.EFF_PIX(EFF_PIX), .OB_PIX(OB_PIX), .LEAD_PIX(LEAD_PIX),
                   .TRAIL_PIX(TRAIL_PIX), .PCNT_W(PCNT_W), .IDX_W(IDX_W)) u_cls (
      .act_i(st_q == ST_SHIFT), .mode_i(mode_q), .pcnt_i(pcnt),
      .class_o(pix_class_o), .idx_o(pix_idx_o), .in_line_o(in_line), .last_o(last_pix));

   ccd_strobe_gen #(.DLY_W(DLY_W)) u_stb (
      .clk_i, .rst_ni, .act_i(in_line), .per_start_i(per_start),
      .dly_i(smp_dly_i), .stb_o(smp_stb_o));

   assign rog_o       = (st_q == ST_GATE);
   assign line_done_o = last_pix & per_last;
   assign busy_o      = (st_q != ST_IDLE);
   assign warm_o      = (st_q == ST_WARM);
   assign mode_o      = mode_q;

   // checker counters for guard and gate windows
   logic [TM_W:0] quiet_q, since_rog_q, gate_len_q;
   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         quiet_q     <= '0;
         since_rog_q <= (TM_W+1)'(GUARD_CYC);
         gate_len_q  <= '0;
      end else begin
         quiet_q     <= !sclk_o ? '0 :
                        (quiet_q >= (TM_W+1)'(GUARD_CYC)) ? quiet_q : quiet_q + 1'b1;
         since_rog_q <= rog_o ? '0 :
                        (since_rog_q >= (TM_W+1)'(GUARD_CYC)) ? since_rog_q : since_rog_q + 1'b1;
         gate_len_q  <= rog_o ? gate_len_q + 1'b1 : '0;
      end
   end

   // R3
   guard_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rog_o) |-> quiet_q >= (TM_W+1)'(GUARD_CYC));
   // R3
   guard_post_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(sclk_o) |-> since_rog_q >= (TM_W+1)'(GUARD_CYC));
   // R4
   gate_width_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rog_o) |-> gate_len_q == (TM_W+1)'(ROG_CYC));
   // R4
   gate_still_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rog_o |-> (sclk_o && !smp_stb_o));
   // R9
   done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      line_done_o |=> pix_class_o == PX_IDLE);

endmodule

// File: tb/ccd_readout_seq_test.sv
module ccd_readout_seq_test;
   localparam int HALF  = 63;
   localparam int ROGC  = 250;
   localparam int GRD   = 250;
   localparam int WARM  = 40;
   localparam int EFF   = 16;
   localparam int OB    = 3;
   localparam int LEAD  = 8;
   localparam int TRAIL = 4;
   localparam int EXTRA = 1;
   localparam int PER   = 2 * HALF;
   localparam int SHOTS = LEAD + 1 + EFF + TRAIL + EXTRA;
   localparam int LINE_CYC = 2 * GRD + ROGC + SHOTS * PER;

   logic clk = 0, rst_n = 0, start = 0, hold = 0;
   logic [7:0] dly = 8'd5;
   logic sclk, rog, mode, stb, done, busy, warm;
   logic [1:0] cls;
   logic [11:0] idx;

   int checks = 0, fails = 0;
   int n_done = 0, n_stb = 0, n_rog = 0, rises_pre = 0;
   logic sclk_prev = 1'b1, rog_prev = 1'b0;

   always #2 clk = ~clk;

   ccd_readout_seq #(.SYS_PS(4000), .HALF_CYC(HALF), .ROG_CYC(ROGC), .GUARD_CYC(GRD),
      .WARM_PULSES(WARM), .EFF_PIX(EFF), .OB_PIX(OB), .LEAD_PIX(LEAD),
      .TRAIL_PIX(TRAIL), .EXTRA_PULSES(EXTRA)) uut (
      .clk_i(clk), .rst_ni(rst_n), .start_i(start), .hold_mode_i(hold),
      .smp_dly_i(dly), .sclk_o(sclk), .rog_o(rog), .mode_o(mode),
      .pix_class_o(cls), .pix_idx_o(idx), .smp_stb_o(stb),
      .line_done_o(done), .busy_o(busy), .warm_o(warm));

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
      end
   endtask

   // behavioural reference: phase 0 warm, 1 idle, 2 line
   int m_ph, m_t;
   logic m_pend, m_mode;
   always @(posedge clk) begin
      if (!rst_n) begin
         m_ph <= 0; m_t <= 0; m_pend <= 1'b0; m_mode <= 1'b0;
      end else begin
         case (m_ph)
            0: begin
               m_pend <= m_pend | start;
               if (m_t == WARM * PER - 1) begin m_ph <= 1; m_t <= 0; end
               else m_t <= m_t + 1;
            end
            1: if (m_pend || start) begin
               m_ph <= 2; m_t <= 0; m_pend <= 1'b0; m_mode <= hold;
            end
            default: begin
               m_pend <= m_pend | start;
               if (m_t == LINE_CYC - 1) begin m_ph <= 1; m_t <= 0; end
               else m_t <= m_t + 1;
            end
         endcase
      end
   end

   always @(negedge clk) begin
      if (rst_n) begin
         int e_sclk, e_rog, e_cls, e_idx, e_stb, e_done, p, w, s, lead, len;
         string rs, rc;
         e_sclk = 1; e_rog = 0; e_cls = 3; e_idx = 0; e_stb = 0; e_done = 0;
         rs = "R3";
         lead = LEAD + int'(m_mode);
         len  = lead + EFF + TRAIL;
         rc = m_mode ? "R7 class" : "R6 class";
         if (m_ph == 0) begin
            e_sclk = ((m_t % PER) >= HALF); rs = "R1";
         end else if (m_ph == 2) begin
            if (m_t >= GRD && m_t < GRD + ROGC) begin e_rog = 1; rs = "R4"; end
            else if (m_t >= 2 * GRD + ROGC) begin
               s = m_t - (2 * GRD + ROGC);
               p = s / PER; w = s % PER;
               e_sclk = (w >= HALF); rs = "R5";
               if (p < len) begin
                  if (p < lead - OB) e_cls = 0;
                  else if (p < lead) e_cls = 1;
                  else if (p < lead + EFF) begin e_cls = 2; e_idx = p - lead; end
                  else e_cls = 0;
                  e_stb  = (w == int'(dly));
                  e_done = (p == len - 1) && (w == PER - 1);
               end
            end
         end
         chk(rs, int'(sclk), e_sclk);
         chk("R4 gate", int'(rog), e_rog);
         chk(rc, int'(cls), e_cls);
         chk({rc, " index"}, int'(idx), e_idx);
         chk("R8 strobe", int'(stb), e_stb);
         chk("R9 done", int'(done), e_done);
         chk("R2 busy", int'(busy), int'(m_ph != 1));
         chk("R1 warm", int'(warm), int'(m_ph == 0));
         chk("R7 mode", int'(mode), int'(m_mode));
         if (done) n_done++;
         if (stb) n_stb++;
         if (rog && !rog_prev) n_rog++;
         if (sclk && !sclk_prev && n_rog == 0) rises_pre++;
         sclk_prev = sclk;
         rog_prev  = rog;
      end
   end

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // reset state, first cycle (R1)
      @(negedge clk);
      chk("R1 reset sclk", int'(sclk), 0);
      chk("R1 reset class", int'(cls), 3);
      // two starts during warm-up merge into one line (R10)
      repeat (100) @(negedge clk);
      pulse_start();
      repeat (50) @(negedge clk);
      pulse_start();
      while (!rog) @(negedge clk);
      // mid-line: new request and a hold change, which must not affect this line (R7, R10)
      repeat (1000) @(negedge clk);
      hold = 1'b1;
      pulse_start();
      while (n_done < 2) @(negedge clk);
      wait_idle();
      // delay zero, hold mode (R8, R7)
      dly = 8'd0;
      pulse_start(); wait_idle();
      // last cycle of the period, no hold (R8, R6)
      dly = 8'(PER - 1); hold = 1'b0;
      pulse_start(); wait_idle();
      // delay of a full period: no strobe (R8)
      dly = 8'(PER); hold = 1'b1;
      pulse_start(); wait_idle();
      repeat (10) @(negedge clk);
      chk("R1 warm-up pulses", rises_pre, WARM);
      chk("R10 lines run", n_done, 5);
      chk("R4 gate count", n_rog, 5);
      chk("R8 strobe total", n_stb,
          (LEAD + EFF + TRAIL) + (LEAD + 1 + EFF + TRAIL) * 2 + (LEAD + EFF + TRAIL));
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++; fails++;
      $display("FAIL R2 watchdog: actual busy %0d expected run complete", busy);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule